// File: doc/BRIEF.md
# Push-down stack pointer engine

This block owns the stack pointer of a stack that grows toward lower addresses and runs the memory handshake for each stack access. A client raises a push request with a 32-bit item or a pop request; the engine forms the memory address as the stack segment base plus the pointer and drives write enable and write data. A push moves the pointer down by one item and then stores at the new top. A pop reads the current top and then moves the pointer up by one item. The client may also load the pointer directly, for example when a new stack is set up.

The memory port is single-cycle. Address, write enable and write data are driven combinationally in the request cycle. Read data returns on `mem_rdata` one cycle after the address. The pop result is presented on `pop_data` with a one-cycle `pop_valid` strobe in that following cycle. All pointer and address arithmetic wraps modulo 2^32.

A small state machine records what the engine did in the previous cycle, and the registered strobes are decoded from it. Its states are ST_IDLE (nothing done), ST_PUSHED (a push was written), ST_POPPED (a pop read is returning), ST_LOADED (the pointer was loaded) and ST_FAULT (push and pop arrived together and were refused). Each cycle the decoded request selects the next state: load goes to ST_LOADED, a lone push to ST_PUSHED, a lone pop to ST_POPPED, push with pop to ST_FAULT, and no request to ST_IDLE. Any state can move to any state.

Top module: `stack_ptr_engine`

## Requirements
- R1: After reset, `sp_value` is 0, `pop_valid` and `conflict_err` are 0, and `mem_we` is 0 while no request is raised.
- R2: A push with no pop and no load drives `mem_we`=1, `mem_addr` = `seg_base` + `sp_value` − 4 and `mem_wdata` = `push_data` in the same cycle. `sp_value` is 4 lower in the next cycle.
- R3: A pop with no push and no load drives `mem_we`=0 and `mem_addr` = `seg_base` + `sp_value` in the same cycle, and `sp_value` is 4 higher in the next cycle. In that next cycle `pop_valid` is 1 for exactly one cycle and `pop_data` equals `mem_rdata`.
- R4: Items pushed and later popped come back in last-in, first-out order.
- R5: A load sets `sp_value` to `load_value` in the next cycle, whatever push and pop show. It causes no write, no `pop_valid` and no `conflict_err`.
- R6: Push and pop together without load cause no write and leave `sp_value` unchanged. `conflict_err` is 1 for one cycle in the next cycle, and `pop_valid` stays 0.
- R7: Pointer and address arithmetic wraps modulo 2^32. A push at pointer 0 gives pointer 0xFFFFFFFC, and a pop there gives pointer 0.
- R8: With no request, `sp_value` holds, `mem_we` is 0 and `pop_valid` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_req | input | 1 | Push request |
| push_data | input | 32 | Item to push |
| pop_req | input | 1 | Pop request |
| load_req | input | 1 | Direct pointer load, overrides push and pop |
| load_value | input | 32 | Pointer value to load |
| seg_base | input | 32 | Stack segment base address |
| sp_value | output | 32 | Current stack pointer (top of stack offset) |
| mem_addr | output | 32 | Memory address, base plus pointer |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after address |
| pop_valid | output | 1 | Pop result strobe |
| pop_data | output | 32 | Popped item |
| conflict_err | output | 1 | Push and pop were raised together and refused |

## Verification
The checker checks on every cycle how the pointer moves after push, pop, load, conflict and idle cycles. It also checks that the write enable appears only on a lone push, and that pop and error strobes follow the right request one cycle later. Only the bench's scenarios can show last-in, first-out order through a real memory. The same holds for popped data matching what was stored, and for wrap-around of both pointer and address at the 2^32 boundary.

// File: rtl/stack_ptr_pkg.sv
package stack_ptr_pkg;
    typedef enum logic [2:0] {
        OP_NONE,
        OP_PUSH,
        OP_POP,
        OP_LOAD,
        OP_CLASH
    } stk_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSHED,
        ST_POPPED,
        ST_LOADED,
        ST_FAULT
    } stk_state_e;
endpackage

// File: rtl/stack_op_decode.sv
module stack_op_decode
    import stack_ptr_pkg::*;
(
    input  logic    push_req,
    input  logic    pop_req,
    input  logic    load_req,
    output stk_op_e op
);
    always_comb begin
        if (load_req)
            op = OP_LOAD;
        else if (push_req && pop_req)
            op = OP_CLASH;
        else if (push_req)
            op = OP_PUSH;
        else if (pop_req)
            op = OP_POP;
        else
            op = OP_NONE;
    end
endmodule

// File: rtl/stack_addr_gen.sv
module stack_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int STEP   = 4
) (
    input  logic [ADDR_W-1:0] sp,
    input  logic [ADDR_W-1:0] base,
    input  logic              use_lower,
    output logic [ADDR_W-1:0] sp_down,
    output logic [ADDR_W-1:0] sp_up,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    always_comb begin
        sp_down = sp - STEP_V;
        sp_up   = sp + STEP_V;
        addr    = base + (use_lower ? sp_down : sp);
    end
endmodule

// File: rtl/stack_ptr_engine.sv
module stack_ptr_engine
    import stack_ptr_pkg::*;
#(
    parameter int          DATA_W   = 32,
    parameter int          ADDR_W   = 32,
    parameter int          STEP     = 4,
    parameter logic [31:0] RESET_SP = 32'h0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_req,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop_req,
    input  logic              load_req,
    input  logic [ADDR_W-1:0] load_value,
    input  logic [ADDR_W-1:0] seg_base,
    output logic [ADDR_W-1:0] sp_value,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              pop_valid,
    output logic [DATA_W-1:0] pop_data,
    output logic              conflict_err
);
    stk_op_e            op;
    stk_state_e         state, state_nx;
    logic [ADDR_W-1:0]  sp_q, sp_nx, sp_down, sp_up;

    stack_op_decode u_dec (
        .push_req (push_req),
        .pop_req  (pop_req),
        .load_req (load_req),
        .op       (op)
    );

    stack_addr_gen #(.ADDR_W(ADDR_W), .STEP(STEP)) u_agen (
        .sp        (sp_q),
        .base      (seg_base),
        .use_lower (op == OP_PUSH),
        .sp_down   (sp_down),
        .sp_up     (sp_up),
        .addr      (mem_addr)
    );

    // next state and pointer from the decoded request
    always_comb begin
        state_nx = ST_IDLE;
        sp_nx    = sp_q;
        unique case (op)
            OP_LOAD:  begin state_nx = ST_LOADED; sp_nx = load_value; end
            OP_PUSH:  begin state_nx = ST_PUSHED; sp_nx = sp_down;    end
            OP_POP:   begin state_nx = ST_POPPED; sp_nx = sp_up;      end
            OP_CLASH: begin state_nx = ST_FAULT;                      end
            OP_NONE:  begin state_nx = ST_IDLE;                       end
            default:  begin state_nx = ST_IDLE;                       end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            sp_q  <= ADDR_W'(RESET_SP);
        end else begin
            state <= state_nx;
            sp_q  <= sp_nx;
        end
    end

    // outputs
    always_comb begin
        pop_valid    = 1'b0;
        conflict_err = 1'b0;
        unique case (state)
            ST_POPPED: pop_valid    = 1'b1;
            ST_FAULT:  conflict_err = 1'b1;
            ST_IDLE, ST_PUSHED, ST_LOADED: ;
            default: ;
        endcase
    end

    assign mem_we    = (op == OP_PUSH);
    assign mem_wdata = push_data;
    assign pop_data  = mem_rdata;
    assign sp_value  = sp_q;
endmodule

// File: rtl/stack_ptr_checker.sv
module stack_ptr_checker #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int STEP   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              push_req,
    input logic [DATA_W-1:0] push_data,
    input logic              pop_req,
    input logic              load_req,
    input logic [ADDR_W-1:0] load_value,
    input logic [ADDR_W-1:0] seg_base,
    input logic [ADDR_W-1:0] sp_value,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_we,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              pop_valid,
    input logic              conflict_err
);
    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    logic lone_push, lone_pop, clash, idle;
    assign lone_push = !load_req && push_req && !pop_req;
    assign lone_pop  = !load_req && pop_req && !push_req;
    assign clash     = !load_req && push_req && pop_req;
    assign idle      = !load_req && !push_req && !pop_req;

    a_r2_push_port: assert property (@(posedge clk) disable iff (!rst_n)
        lone_push |-> (mem_we && mem_addr == seg_base + sp_value - STEP_V && mem_wdata == push_data));
    a_r2_push_dec: assert property (@(posedge clk) disable iff (!rst_n)
        lone_push |=> (sp_value == $past(sp_value) - STEP_V));
    a_r3_pop_inc: assert property (@(posedge clk) disable iff (!rst_n)
        lone_pop |=> (sp_value == $past(sp_value) + STEP_V && pop_valid));
    a_r3_pop_addr: assert property (@(posedge clk) disable iff (!rst_n)
        lone_pop |-> (!mem_we && mem_addr == seg_base + sp_value));
    a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
        load_req |=> (sp_value == $past(load_value) && !pop_valid && !conflict_err));
    a_r5_load_nowrite: assert property (@(posedge clk) disable iff (!rst_n)
        load_req |-> !mem_we);
    a_r6_clash: assert property (@(posedge clk) disable iff (!rst_n)
        clash |=> (conflict_err && !pop_valid && sp_value == $past(sp_value)));
    a_r6_clash_nowrite: assert property (@(posedge clk) disable iff (!rst_n)
        clash |-> !mem_we);
    a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
        idle |=> ($stable(sp_value) && !pop_valid && !conflict_err));
    a_r3_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(pop_valid && conflict_err));
endmodule

bind stack_ptr_engine stack_ptr_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .STEP(STEP)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .push_req     (push_req),
    .push_data    (push_data),
    .pop_req      (pop_req),
    .load_req     (load_req),
    .load_value   (load_value),
    .seg_base     (seg_base),
    .sp_value     (sp_value),
    .mem_addr     (mem_addr),
    .mem_we       (mem_we),
    .mem_wdata    (mem_wdata),
    .pop_valid    (pop_valid),
    .conflict_err (conflict_err)
);

// File: tb/stack_ptr_engine_test.sv
module stack_ptr_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_req = 1'b0, pop_req = 1'b0, load_req = 1'b0;
    logic [31:0] push_data = '0, load_value = '0, seg_base = 32'h0000_1000;
    logic [31:0] sp_value, mem_addr, mem_wdata, mem_rdata, pop_data;
    logic        mem_we, pop_valid, conflict_err;

    int errors = 0;
    int checks = 0;

    logic [31:0] ram [0:63];

    always #5 clk = ~clk;

    stack_ptr_engine uut (
        .clk(clk), .rst_n(rst_n), .push_req(push_req), .push_data(push_data),
        .pop_req(pop_req), .load_req(load_req), .load_value(load_value),
        .seg_base(seg_base), .sp_value(sp_value), .mem_addr(mem_addr),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .pop_valid(pop_valid), .pop_data(pop_data), .conflict_err(conflict_err)
    );

    // bench memory: synchronous write and read
    always @(posedge clk) begin
        if (mem_we) ram[mem_addr[7:2]] <= mem_wdata;
        mem_rdata <= ram[mem_addr[7:2]];
    end

    // reference model
    logic [31:0] ref_sp = 32'h0;
    logic [31:0] ref_mem [int];
    bit          ex_valid = 1'b0, ex_err = 1'b0;
    logic [31:0] ex_data = '0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_regs(input string req);
        chk({req, " sp"}, sp_value, ref_sp);
        chk({req, " pop_valid"}, {31'b0, pop_valid}, {31'b0, ex_valid});
        chk({req, " conflict_err"}, {31'b0, conflict_err}, {31'b0, ex_err});
        if (ex_valid) chk({req, " pop_data"}, pop_data, ex_data);
    endtask

    // one cycle: drive at negedge, check comb outputs, advance model, check registered outputs
    task automatic step(input string req, input bit pu, input bit po, input bit ld,
                        input logic [31:0] d, input logic [31:0] lv);
        logic [31:0] a;
        push_req = pu; pop_req = po; load_req = ld; push_data = d; load_value = lv;
        #1;
        ex_valid = 1'b0; ex_err = 1'b0;
        if (ld) begin
            chk({req, " no write"}, {31'b0, mem_we}, 32'd0);
            ref_sp = lv;
        end else if (pu && po) begin
            chk({req, " no write"}, {31'b0, mem_we}, 32'd0);
            ex_err = 1'b1;
        end else if (pu) begin
            a = seg_base + ref_sp - 32'd4;
            chk({req, " we"}, {31'b0, mem_we}, 32'd1);
            chk({req, " addr"}, mem_addr, a);
            chk({req, " wdata"}, mem_wdata, d);
            ref_mem[int'(a[7:2])] = d;
            ref_sp = ref_sp - 32'd4;
        end else if (po) begin
            a = seg_base + ref_sp;
            chk({req, " we"}, {31'b0, mem_we}, 32'd0);
            chk({req, " addr"}, mem_addr, a);
            ex_valid = 1'b1;
            ex_data = ref_mem.exists(int'(a[7:2])) ? ref_mem[int'(a[7:2])] : 32'h0;
            ref_sp = ref_sp + 32'd4;
        end else begin
            chk({req, " idle no write"}, {31'b0, mem_we}, 32'd0);
        end
        @(negedge clk);
        check_regs(req);
    endtask

    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) ram[i] = 32'h0;
        @(negedge clk); @(negedge clk);
        // R1 reset state
        check_regs("R1");
        chk("R1 we", {31'b0, mem_we}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 and R8: stay idle
        step("R8", 0, 0, 0, 0, 0);
        // R5 load a working pointer
        step("R5", 0, 0, 1, 0, 32'h40);
        // R2 pushes, R4 LIFO pops
        step("R2", 1, 0, 0, 32'hA1A1_0001, 0);
        step("R2", 1, 0, 0, 32'hB2B2_0002, 0);
        step("R2", 1, 0, 0, 32'hC3C3_0003, 0);
        step("R8", 0, 0, 0, 0, 0);
        step("R4", 0, 1, 0, 0, 0);
        step("R4", 0, 1, 0, 0, 0);
        // R6 clash while stack holds one item
        step("R6", 1, 1, 0, 32'hDEAD_BEEF, 0);
        step("R4", 0, 1, 0, 0, 0);
        // R3 back-to-back push then pop
        step("R3", 1, 0, 0, 32'h1234_5678, 0);
        step("R3", 0, 1, 0, 0, 0);
        // R5 load overrides push and pop together
        step("R5", 1, 1, 1, 32'hFFFF_FFFF, 32'h20);
        step("R5", 1, 0, 1, 32'h5555_5555, 32'h30);
        step("R3", 0, 1, 0, 0, 0);
        // R7 wrap-around at zero with a different base
        seg_base = 32'h0000_0080;
        step("R7", 0, 0, 1, 0, 32'h0);
        step("R7", 1, 0, 0, 32'h7777_0007, 0);
        step("R7", 1, 0, 0, 32'h8888_0008, 0);
        step("R7", 0, 1, 0, 0, 0);
        step("R7", 0, 1, 0, 0, 0);
        step("R8", 0, 0, 0, 0, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule